// File: doc/BRIEF.md
# Filter Chain Stage Sequencer

This block decides, for every output period of a decimation engine, which filter stages are computed and for which channels. At the start of a period it captures a configuration word that holds a channel-count field and an output-stage select field. It then issues (stage, channel) compute requests one at a time to a shared arithmetic engine. Each request waits for the engine's one-cycle done handshake before the next one is issued.

The chain order is sinc, FIR1, FIR2, then the IIR stages. Selecting an output stage runs every stage before it. The exception is the second-order IIR output, which skips the first-order IIR stage. The third-order output runs both IIR stages. All active channels are served for one stage before the sequencer moves on to the next stage. The requests of the final stage carry a flag that marks the result as the one routed to the output. When the last request finishes, a period-complete pulse is issued.

Top module: `filt_stage_seq`

## Requirements
- R1: After reset, req_valid, period_done and cfg_err are all low.
- R2: Configuration bits 1:0 hold k, and k+1 channels are active. Requests use channel indices 0 to k on req_chan, where index 0 is the first channel. No request is issued for an index above k.
- R3: Configuration bits 10:8 select the output: 0 sinc, 1 FIR1, 2 FIR2, 3 first-order IIR, 4 second-order IIR, 5 third-order IIR. req_stage is encoded as 0 sinc, 1 FIR1, 2 FIR2, 3 first-order IIR, 4 second-order IIR. Stages run in ascending code order, and each stage up to the selected one is included.
- R4: Select code 4 runs stages 0, 1, 2 and 4 and never issues stage 3.
- R5: Select code 5 runs stages 0, 1, 2, 3 and 4.
- R6: Select codes 6 and 7 run stage 0 only. They set cfg_err, which stays high until the next period start captures a valid code.
- R7: Within a period, every active channel is requested for a stage before any request for the next stage is issued.
- R8: A request, with its stage and channel, holds unchanged until eng_done is seen high.
- R9: period_done pulses high for exactly one cycle, in the cycle after the done of the last request. req_valid is low in that cycle.
- R10: The configuration word is sampled only when period_start is seen while idle. Configuration changes and period_start pulses during a period have no effect.
- R11: req_out is high exactly on requests of the final stage of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | CFG_W | Filter configuration word |
| period_start | input | 1 | Starts a period when idle |
| eng_done | input | 1 | Engine finished the current request |
| req_valid | output | 1 | Compute request pending |
| req_stage | output | 3 | Stage of the current request |
| req_chan | output | CH_W | Channel index of the current request |
| req_out | output | 1 | Current stage feeds the output |
| period_done | output | 1 | One-cycle pulse at the end of a period |
| cfg_err | output | 1 | Captured select code was invalid |

## Verification
Every valid select code is run. Comparing the full request sequences separates a correct stage walk from one that omits a stage, adds one, or ignores the second-order bypass. Channel counts of one to four under a fixed select show whether the channel loop stops at the right index and stays inside each stage. Further runs cover an engine that delays its done, a configuration change and a stray start during a period, and the two invalid select codes. These show that a request holds until its done arrives and that the configuration is captured only at the start of a period. The invalid-code runs also check that the error flag clears on the next valid period.

// File: rtl/filt_seq_pkg.sv
package filt_seq_pkg;
   localparam int N_STAGE = 5;
   localparam int STG_W   = 3;
   localparam int N_SEL   = 6;

   typedef enum logic [STG_W-1:0] {
      STG_SINC = 3'd0,
      STG_FIR1 = 3'd1,
      STG_FIR2 = 3'd2,
      STG_IIR1 = 3'd3,
      STG_IIR2 = 3'd4
   } stage_e;

   // Stage set for an output select code; bit i enables stage code i.
   function automatic logic [N_STAGE-1:0] sel_to_mask(input logic [STG_W-1:0] sel);
      case (sel)
         3'd0:    return 5'b00001;
         3'd1:    return 5'b00011;
         3'd2:    return 5'b00111;
         3'd3:    return 5'b01111;
         3'd4:    return 5'b10111;   // second-order output bypasses first-order stage
         3'd5:    return 5'b11111;
         default: return 5'b00001;
      endcase
   endfunction
endpackage

// File: rtl/filt_cfg_decode.sv
module filt_cfg_decode
   import filt_seq_pkg::*;
#(
   parameter int CFG_W   = 16,
   parameter int CH_LSB  = 0,
   parameter int CH_W    = 2,
   parameter int SEL_LSB = 8,
   parameter int SEL_W   = 3
) (
   input  logic [CFG_W-1:0]   cfg,
   output logic [CH_W-1:0]    last_chan,
   output logic [N_STAGE-1:0] stage_mask,
   output logic               sel_bad
);
   logic [SEL_W-1:0] sel;

   generate
      if (CH_LSB + CH_W > CFG_W) begin : g_bad_ch
         $error("channel field exceeds configuration width");
      end
      if (SEL_LSB + SEL_W > CFG_W) begin : g_bad_sel
         $error("select field exceeds configuration width");
      end
      if (SEL_W != STG_W) begin : g_bad_selw
         $error("select field width must match stage code width");
      end
   endgenerate

   assign last_chan  = cfg[CH_LSB +: CH_W];
   assign sel        = cfg[SEL_LSB +: SEL_W];
   assign sel_bad    = (int'(sel) >= N_SEL);
   assign stage_mask = sel_to_mask(sel);

   logic unused_cfg;
   assign unused_cfg = ^cfg;
endmodule

// File: rtl/filt_stage_pick.sv
module filt_stage_pick
   import filt_seq_pkg::*;
(
   input  logic [N_STAGE-1:0] mask,
   input  logic [STG_W-1:0]   cur,
   output logic [STG_W-1:0]   nxt,
   output logic [STG_W-1:0]   final_stg
);
   // Candidate per position: enabled and above the current stage.
   logic [N_STAGE-1:0] above;

   genvar g;
   generate
      for (g = 0; g < N_STAGE; g++) begin : g_above
         assign above[g] = mask[g] && (g > int'(cur));
      end
   endgenerate

   always_comb begin
      nxt = cur;
      for (int i = N_STAGE - 1; i >= 0; i--) begin
         if (above[i]) nxt = STG_W'(i);
      end
   end

   always_comb begin
      final_stg = '0;
      for (int i = 0; i < N_STAGE; i++) begin
         if (mask[i]) final_stg = STG_W'(i);
      end
   end
endmodule

// File: rtl/filt_stage_seq.sv
module filt_stage_seq
   import filt_seq_pkg::*;
#(
   parameter int CFG_W   = 16,
   parameter int CH_LSB  = 0,
   parameter int CH_W    = 2,
   parameter int SEL_LSB = 8,
   parameter int SEL_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             period_start,
   input  logic             eng_done,
   output logic             req_valid,
   output logic [2:0]       req_stage,
   output logic [CH_W-1:0]  req_chan,
   output logic             req_out,
   output logic             period_done,
   output logic             cfg_err
);
   logic [CH_W-1:0]    dec_last;
   logic [N_STAGE-1:0] dec_mask;
   logic               dec_bad;

   logic               run_q;
   logic [STG_W-1:0]   stg_q;
   logic [CH_W-1:0]    chan_q;
   logic [CH_W-1:0]    lastch_q;
   logic [N_STAGE-1:0] mask_q;
   logic               err_q;
   logic               done_q;
   logic [STG_W-1:0]   stg_nxt;
   logic [STG_W-1:0]   stg_final;

   filt_cfg_decode #(
      .CFG_W(CFG_W), .CH_LSB(CH_LSB), .CH_W(CH_W),
      .SEL_LSB(SEL_LSB), .SEL_W(SEL_W)
   ) u_dec (
      .cfg       (cfg_word),
      .last_chan (dec_last),
      .stage_mask(dec_mask),
      .sel_bad   (dec_bad)
   );

   filt_stage_pick u_pick (
      .mask     (mask_q),
      .cur      (stg_q),
      .nxt      (stg_nxt),
      .final_stg(stg_final)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         stg_q    <= STG_SINC;
         chan_q   <= '0;
         lastch_q <= '0;
         mask_q   <= '0;
         err_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!run_q) begin
            if (period_start) begin
               run_q    <= 1'b1;
               mask_q   <= dec_mask;
               lastch_q <= dec_last;
               err_q    <= dec_bad;
               stg_q    <= STG_SINC;
               chan_q   <= '0;
            end
         end else if (eng_done) begin
            if (chan_q == lastch_q) begin
               chan_q <= '0;
               if (stg_q == stg_final) begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  stg_q <= stg_nxt;
               end
            end else begin
               chan_q <= chan_q + 1'b1;
            end
         end
      end
   end

   assign req_valid   = run_q;
   assign req_stage   = stg_q;
   assign req_chan    = chan_q;
   assign req_out     = run_q && (stg_q == stg_final);
   assign period_done = done_q;
   assign cfg_err     = err_q;
endmodule

// File: rtl/filt_seq_chk.sv
module filt_seq_chk #(
   parameter int CH_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            eng_done,
   input logic            req_valid,
   input logic [2:0]      req_stage,
   input logic [CH_W-1:0] req_chan,
   input logic            req_out,
   input logic            period_done,
   input logic            cfg_err,
   input logic [CH_W-1:0] lastch
);
   a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !eng_done) |=> (req_valid && $stable(req_stage) && $stable(req_chan)));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      period_done |=> !period_done);

   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      period_done |-> !req_valid);

   a_r2_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_chan <= lastch));

   a_r6_err_sinc: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cfg_err) |-> (req_stage == 3'd0));

   a_r7_stage_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && eng_done && (req_chan != lastch)) |=> $stable(req_stage));

   a_r3_stage_legal: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_stage <= 3'd4));

   a_r11_out_valid: assert property (@(posedge clk) disable iff (!rst_n)
      req_out |-> req_valid);
endmodule

bind filt_stage_seq filt_seq_chk #(.CH_W(CH_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .eng_done   (eng_done),
   .req_valid  (req_valid),
   .req_stage  (req_stage),
   .req_chan   (req_chan),
   .req_out    (req_out),
   .period_done(period_done),
   .cfg_err    (cfg_err),
   .lastch     (lastch_q)
);

// File: tb/sim_filt_stage_seq.sv
`timescale 1ns/1ps
module sim_filt_stage_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_word = '0;
   logic        period_start = 1'b0;
   logic        eng_done = 1'b0;
   logic        req_valid, req_out, period_done, cfg_err;
   logic [2:0]  req_stage;
   logic [1:0]  req_chan;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   filt_stage_seq u0 (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
      .period_start(period_start), .eng_done(eng_done),
      .req_valid(req_valid), .req_stage(req_stage), .req_chan(req_chan),
      .req_out(req_out), .period_done(period_done), .cfg_err(cfg_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expected stage list for a select code, built from R3..R6.
   task automatic stage_list(input int sel, output int st[5], output int n);
      st = '{0, 0, 0, 0, 0};
      case (sel)
         0: begin st[0] = 0; n = 1; end
         1: begin st = '{0, 1, 0, 0, 0}; n = 2; end
         2: begin st = '{0, 1, 2, 0, 0}; n = 3; end
         3: begin st = '{0, 1, 2, 3, 0}; n = 4; end
         4: begin st = '{0, 1, 2, 4, 0}; n = 4; end
         5: begin st = '{0, 1, 2, 3, 4}; n = 5; end
         default: begin st[0] = 0; n = 1; end
      endcase
   endtask

   // One full period; stall = extra cycles before done, poke = disturb inputs mid-period.
   task automatic run_period(input logic [15:0] cfg, input int stall, input bit poke, input string tag);
      int st[5];
      int n;
      int nch;
      int sel;
      sel = int'(cfg[10:8]);
      nch = int'(cfg[1:0]) + 1;
      stage_list(sel, st, n);
      @(negedge clk);
      cfg_word = cfg;
      period_start = 1'b1;
      @(negedge clk);
      period_start = 1'b0;
      for (int s = 0; s < n; s++) begin
         for (int c = 0; c < nch; c++) begin
            chk(req_valid === 1'b1, {tag, " R2 req_valid"}, int'(req_valid), 1);
            chk(int'(req_stage) == st[s], {tag, " R3 R4 R5 R7 stage"}, int'(req_stage), st[s]);
            chk(int'(req_chan) == c, {tag, " R2 R7 chan"}, int'(req_chan), c);
            chk(req_out === (s == n - 1), {tag, " R11 req_out"}, int'(req_out), int'(s == n - 1));
            if (poke && s == 0 && c == 0) begin
               cfg_word = 16'h0503;
               period_start = 1'b1;
            end
            for (int w = 0; w < stall; w++) begin
               @(negedge clk);
               period_start = 1'b0;
               chk(int'(req_stage) == st[s] && int'(req_chan) == c && req_valid,
                   {tag, " R8 hold"}, int'(req_stage), st[s]);
            end
            eng_done = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
            period_start = 1'b0;
         end
      end
      chk(period_done === 1'b1, {tag, " R9 period_done"}, int'(period_done), 1);
      chk(req_valid === 1'b0, {tag, " R9 idle"}, int'(req_valid), 0);
      chk(cfg_err === (sel > 5), {tag, " R6 cfg_err"}, int'(cfg_err), int'(sel > 5));
      @(negedge clk);
      chk(period_done === 1'b0, {tag, " R9 single pulse"}, int'(period_done), 0);
      chk(req_valid === 1'b0, {tag, " R10 no restart"}, int'(req_valid), 0);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(req_valid === 1'b0, "R1 req_valid", int'(req_valid), 0);
      chk(period_done === 1'b0, "R1 period_done", int'(period_done), 0);
      chk(cfg_err === 1'b0, "R1 cfg_err", int'(cfg_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_select_sweep;
      for (int s = 0; s < 6; s++) run_period({5'd0, 3'(s), 8'h03}, 0, 1'b0, "sweep R3");
   endtask

   task automatic t_channels;
      for (int c = 0; c < 4; c++) run_period({5'd0, 3'd2, 6'd0, 2'(c)}, 0, 1'b0, "chans R2");
   endtask

   task automatic t_bypass;
      run_period(16'h0401, 0, 1'b0, "bypass R4");
      run_period(16'h0502, 0, 1'b0, "third R5");
   endtask

   task automatic t_bad_select;
      run_period(16'h0603, 0, 1'b0, "bad6 R6");
      run_period(16'h0700, 0, 1'b0, "bad7 R6");
      run_period(16'h0000, 0, 1'b0, "clear R6");
   endtask

   task automatic t_stall;
      run_period(16'h0301, 3, 1'b0, "stall R8");
   endtask

   task automatic t_mid_change;
      run_period(16'h0100, 2, 1'b1, "midcfg R10");
   endtask

   initial begin
      t_reset();
      t_select_sweep();
      t_channels();
      t_bypass();
      t_bad_select();
      t_stall();
      t_mid_change();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule